// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small shared memory for passing single words between producers and consumers. Each word has one presence tag, full or empty. A producer sends a deposit request, which writes only into an empty word and marks it full. A consumer sends a withdraw request, which reads only from a full word and marks it empty. The tag test and the data access happen together in one memory cycle. No other request can come between them. A request whose condition fails changes nothing and is answered with a retry status, so the requester can poll.

For setup and debug, a port can also peek (read a word regardless of its tag), poke (write a word regardless of its tag) or clear (force a word's tag to empty). Several request ports share one single-access store, and a fixed-priority arbiter serves one request per cycle. The arbiter prefers requests that write data or tags over requests that only read.

The controller is a two-state machine. `S_IDLE` means no response is due in this cycle. `S_ANSWER` means the previous cycle carried at least one request, so responses are now driven. The machine has these transitions:
- `S_IDLE`→`S_ANSWER` and `S_ANSWER`→`S_ANSWER` happen whenever any request is valid.
- `S_ANSWER`→`S_IDLE` and `S_IDLE`→`S_IDLE` happen when no request is valid.

Top module: `fe_tagged_mem`

## Requirements
- R1: Reset leaves every tag empty and drives no response. After reset, a withdraw to any address answers retry with tag 0.
- R2: A deposit (op code 1) to an empty word stores the write data, sets the tag to full and answers OK (status 0).
- R3: A deposit to a full word answers retry (status 1) and leaves the word's data and tag unchanged.
- R4: A withdraw (op code 2) from a full word returns the stored data on `rsp_rdata`, sets the tag to empty and answers OK.
- R5: A withdraw from an empty word answers retry, drives `rsp_rdata` to zero and leaves the data and tag unchanged.
- R6: Peek (op code 3) returns the stored data and poke (op code 4) replaces it. Both always answer OK and leave the tag as it was.
- R7: Clear (op code 5) forces the addressed tag to empty, keeps the data and answers OK. Op code 0 is no request.
- R8: At most one request is served per cycle. The write class (deposit, poke, clear) wins over the read class (withdraw, peek), and within a class the lowest port index wins. Every other requesting port receives wait (status 2), and its request has no effect.
- R9: A request presented at a clock edge is answered at the next edge. The port's `rsp_valid` bit is set, `rsp_tag` shows the served word's tag as it was before the operation, and `rsp_rdata` is zero for all operations except a successful withdraw and a peek.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | NP | One request strobe per port |
| req_op | input | 3*NP | Operation code per port (port i at bits 3i+2:3i) |
| req_addr | input | AW*NP | Word address per port |
| req_wdata | input | DW*NP | Write data per port |
| rsp_valid | output | NP | Response strobe per port, one cycle after the request |
| rsp_status | output | 2*NP | Per port: 0 OK, 1 retry, 2 wait |
| rsp_rdata | output | DW | Data read by the served request |
| rsp_tag | output | 1 | Tag of the served word before the operation |

## Verification
A deposit and a withdraw can both target the same word in one cycle. In that case the arbiter alone decides which one sees the word, and the loser must observe nothing. The bench provokes this by having port 0 withdraw from an empty word while port 1 deposits into it. It expects the withdraw to get wait and the deposit OK, and then expects a lone withdraw on the next request to succeed with the deposited data. The same judgement covers a clear racing a withdraw on a full word, and two deposits to different words, where the higher-index port's word must still be empty afterwards.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PUT   = 3'd1,
        OP_TAKE  = 3'd2,
        OP_PEEK  = 3'd3,
        OP_POKE  = 3'd4,
        OP_CLEAR = 3'd5
    } fe_op_e;

    typedef enum logic [1:0] {
        RS_OK    = 2'd0,
        RS_RETRY = 2'd1,
        RS_WAIT  = 2'd2
    } fe_status_e;

    localparam int OP_W = 3;
    localparam int ST_W = 2;

    function automatic logic is_write_class(logic [OP_W-1:0] op);
        return (op == OP_PUT) || (op == OP_POKE) || (op == OP_CLEAR);
    endfunction

endpackage

// File: rtl/fe_arbiter.sv
module fe_arbiter #(
    parameter int NP = 2,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] valid,
    input  logic [NP-1:0] wr_class,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);

    // Scan from high to low so the lowest index wins; the write pass runs last so it overrides reads.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (valid[i] && !wr_class[i]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(i);
            end
        end
        for (int i = NP - 1; i >= 0; i--) begin
            if (valid[i] && wr_class[i]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/fe_store.sv
module fe_store
    import fe_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [OP_W-1:0] op,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic            ok_q,
    output logic [DW-1:0]   rdata_q,
    output logic            tag_q
);

    logic [DW-1:0]    words [DEPTH];
    logic [DEPTH-1:0] tags;

    logic cur_tag;
    logic hit, data_we, tag_we, tag_nv, rd_sel;

    assign cur_tag = tags[addr];

    // Tag test and data action decided together: one atomic step per cycle.
    always_comb begin
        hit     = 1'b0;
        data_we = 1'b0;
        tag_we  = 1'b0;
        tag_nv  = 1'b0;
        rd_sel  = 1'b0;
        case (op)
            OP_PUT: begin
                hit     = !cur_tag;
                data_we = !cur_tag;
                tag_we  = !cur_tag;
                tag_nv  = 1'b1;
            end
            OP_TAKE: begin
                hit    = cur_tag;
                rd_sel = cur_tag;
                tag_we = cur_tag;
                tag_nv = 1'b0;
            end
            OP_PEEK: begin
                hit    = 1'b1;
                rd_sel = 1'b1;
            end
            OP_POKE: begin
                hit     = 1'b1;
                data_we = 1'b1;
            end
            OP_CLEAR: begin
                hit    = 1'b1;
                tag_we = 1'b1;
                tag_nv = 1'b0;
            end
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (en && data_we) words[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags    <= '0;
            ok_q    <= 1'b0;
            rdata_q <= '0;
            tag_q   <= 1'b0;
        end else if (en) begin
            if (tag_we) tags[addr] <= tag_nv;
            ok_q    <= hit;
            rdata_q <= rd_sel ? words[addr] : '0;
            tag_q   <= cur_tag;
        end
    end

endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem
    import fe_pkg::*;
#(
    parameter int NP = 2,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NP-1:0]      req_valid,
    input  logic [NP*3-1:0]    req_op,
    input  logic [NP*AW-1:0]   req_addr,
    input  logic [NP*DW-1:0]   req_wdata,
    output logic [NP-1:0]      rsp_valid,
    output logic [NP*2-1:0]    rsp_status,
    output logic [DW-1:0]      rsp_rdata,
    output logic               rsp_tag
);

    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    typedef enum logic {S_IDLE, S_ANSWER} ctl_state_e;

    ctl_state_e      state_q, state_d;
    logic [NP-1:0]   wr_class;
    logic            gnt_any;
    logic [IW-1:0]   gnt_idx, gnt_idx_q;
    logic [NP-1:0]   valid_q;
    logic [OP_W-1:0] sel_op;
    logic [AW-1:0]   sel_addr;
    logic [DW-1:0]   sel_wdata;
    logic            st_ok;
    logic [DW-1:0]   st_rdata;
    logic            st_tag;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            wr_class[i] = is_write_class(req_op[i*OP_W +: OP_W]);
        end
    end

    fe_arbiter #(.NP(NP)) u_arb (
        .valid    (req_valid),
        .wr_class (wr_class),
        .gnt_any  (gnt_any),
        .gnt_idx  (gnt_idx)
    );

    assign sel_op    = req_op[gnt_idx*OP_W +: OP_W];
    assign sel_addr  = req_addr[gnt_idx*AW +: AW];
    assign sel_wdata = req_wdata[gnt_idx*DW +: DW];

    fe_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (gnt_any),
        .op      (sel_op),
        .addr    (sel_addr),
        .wdata   (sel_wdata),
        .ok_q    (st_ok),
        .rdata_q (st_rdata),
        .tag_q   (st_tag)
    );

    assign state_d = (|req_valid) ? S_ANSWER : S_IDLE;

    // State register together with the request bookkeeping of the answer cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            valid_q   <= '0;
            gnt_idx_q <= '0;
        end else begin
            state_q   <= state_d;
            valid_q   <= req_valid;
            gnt_idx_q <= gnt_idx;
        end
    end

    // Output process.
    always_comb begin
        rsp_valid  = '0;
        rsp_status = {NP{RS_WAIT}};
        rsp_rdata  = '0;
        rsp_tag    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                rsp_valid = '0;
            end
            S_ANSWER: begin
                rsp_valid = valid_q;
                rsp_rdata = st_rdata;
                rsp_tag   = st_tag;
                for (int i = 0; i < NP; i++) begin
                    if (IW'(i) == gnt_idx_q)
                        rsp_status[i*ST_W +: ST_W] = st_ok ? RS_OK : RS_RETRY;
                end
            end
        endcase
    end

endmodule

// File: rtl/fe_tagged_mem_chk.sv
module fe_tagged_mem_chk
    import fe_pkg::*;
#(
    parameter int NP = 2,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    req_valid,
    input logic [NP*3-1:0]  req_op,
    input logic [NP-1:0]    rsp_valid,
    input logic [NP*2-1:0]  rsp_status,
    input logic [DW-1:0]    rsp_rdata,
    input logic             rsp_tag
);

    logic [NP-1:0]   last_valid;
    logic [NP*3-1:0] last_op;
    logic [NP-1:0]   served;
    logic            last_wr_any;
    logic            bad_prio, bad_cond, bad_plain, bad_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_valid <= '0;
            last_op    <= '0;
        end else begin
            last_valid <= req_valid;
            last_op    <= req_op;
        end
    end

    always_comb begin
        last_wr_any = 1'b0;
        bad_prio    = 1'b0;
        bad_cond    = 1'b0;
        bad_plain   = 1'b0;
        bad_zero    = 1'b0;
        for (int i = 0; i < NP; i++) begin
            served[i] = rsp_valid[i] && (rsp_status[i*2 +: 2] != RS_WAIT);
            if (last_valid[i] && is_write_class(last_op[i*3 +: 3])) last_wr_any = 1'b1;
        end
        for (int i = 0; i < NP; i++) begin
            if (last_wr_any && served[i] && !is_write_class(last_op[i*3 +: 3])) bad_prio = 1'b1;
            if (served[i] && last_op[i*3 +: 3] == OP_PUT &&
                (rsp_status[i*2 +: 2] == RS_OK) == rsp_tag) bad_cond = 1'b1;
            if (served[i] && last_op[i*3 +: 3] == OP_TAKE &&
                (rsp_status[i*2 +: 2] == RS_OK) != rsp_tag) bad_cond = 1'b1;
            if (served[i] && (last_op[i*3 +: 3] == OP_PEEK || last_op[i*3 +: 3] == OP_POKE ||
                              last_op[i*3 +: 3] == OP_CLEAR) && rsp_status[i*2 +: 2] != RS_OK)
                bad_plain = 1'b1;
            if (served[i] && last_op[i*3 +: 3] == OP_TAKE &&
                rsp_status[i*2 +: 2] == RS_RETRY && rsp_rdata != '0) bad_zero = 1'b1;
        end
    end

    a_r8_single_served: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(served) <= 1);

    a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_prio);

    a_r9_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |=> (rsp_valid == $past(req_valid)));

    // R2, R3 and R4: the outcome of deposit and withdraw follows the tag seen before the step.
    a_r3_tag_condition: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_cond);

    a_r6_plain_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_plain);

    a_r5_retry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_zero);

endmodule

bind fe_tagged_mem fe_tagged_mem_chk #(.NP(NP), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .rsp_tag    (rsp_tag)
);

// File: tb/sim_fe_tagged_mem.sv
`timescale 1ns/1ps
module sim_fe_tagged_mem;

    localparam int NP = 2;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int VW = 71;
    localparam int NV = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_valid = '0;
    logic [NP*3-1:0]   req_op = '0;
    logic [NP*AW-1:0]  req_addr = '0;
    logic [NP*DW-1:0]  req_wdata = '0;
    logic [NP-1:0]     rsp_valid;
    logic [NP*2-1:0]   rsp_status;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_tag;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fe_tagged_mem #(.NP(NP), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag));

    // Fields: req[70:67] op0 a0 d0 op1 a1 d1 es0 es1 rdata tag ; es 3 = port idle
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2, 3'd1, 4'd3, 16'h1111, 3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h0,    1'b0}, // R2 deposit empty
        {4'd3, 3'd1, 4'd3, 16'h2222, 3'd0, 4'd0, 16'h0,    2'd1, 2'd3, 16'h0,    1'b1}, // R3 deposit full
        {4'd3, 3'd3, 4'd3, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h1111, 1'b1}, // R3 data kept
        {4'd4, 3'd2, 4'd3, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h1111, 1'b1}, // R4 withdraw full
        {4'd5, 3'd2, 4'd3, 16'h0,    3'd0, 4'd0, 16'h0,    2'd1, 2'd3, 16'h0,    1'b0}, // R5 withdraw empty
        {4'd5, 3'd3, 4'd3, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h1111, 1'b0}, // R5 data kept
        {4'd6, 3'd4, 4'd5, 16'hABCD, 3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h0,    1'b0}, // R6 poke empty
        {4'd6, 3'd2, 4'd5, 16'h0,    3'd0, 4'd0, 16'h0,    2'd1, 2'd3, 16'h0,    1'b0}, // R6 tag still empty
        {4'd2, 3'd1, 4'd5, 16'h5555, 3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h0,    1'b0}, // R2
        {4'd6, 3'd4, 4'd5, 16'h6666, 3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h0,    1'b1}, // R6 poke full
        {4'd6, 3'd3, 4'd5, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h6666, 1'b1}, // R6 peek keeps full
        {4'd7, 3'd5, 4'd5, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h0,    1'b1}, // R7 clear
        {4'd7, 3'd3, 4'd5, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h6666, 1'b0}, // R7 data kept
        {4'd8, 3'd2, 4'd7, 16'h0,    3'd1, 4'd7, 16'h7777, 2'd2, 2'd0, 16'h0,    1'b0}, // R8 deposit beats withdraw
        {4'd8, 3'd2, 4'd7, 16'h0,    3'd0, 4'd0, 16'h0,    2'd0, 2'd3, 16'h7777, 1'b1}, // R8 then withdraw
        {4'd8, 3'd1, 4'd8, 16'h0008, 3'd1, 4'd9, 16'h0009, 2'd0, 2'd2, 16'h0,    1'b0}, // R8 low index wins
        {4'd8, 3'd0, 4'd0, 16'h0,    3'd2, 4'd9, 16'h0,    2'd3, 2'd1, 16'h0,    1'b0}, // R8 loser had no effect
        {4'd8, 3'd3, 4'd8, 16'h0,    3'd3, 4'd9, 16'h0,    2'd0, 2'd2, 16'h0008, 1'b1}, // R8 two peeks
        {4'd8, 3'd2, 4'd8, 16'h0,    3'd5, 4'd8, 16'h0,    2'd2, 2'd0, 16'h0,    1'b1}, // R8 clear beats withdraw
        {4'd7, 3'd2, 4'd8, 16'h0,    3'd0, 4'd0, 16'h0,    2'd1, 2'd3, 16'h0,    1'b0}  // R7 cleared word
    };

    task automatic chk(input bit good, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                         input logic [2:0] o1, input logic [AW-1:0] a1, input logic [DW-1:0] d1);
        req_valid = {o1 != 3'd0, o0 != 3'd0};
        req_op    = {o1, o0};
        req_addr  = {a1, a0};
        req_wdata = {d1, d0};
    endtask

    task automatic idle();
        drive(3'd0, '0, '0, 3'd0, '0, '0);
    endtask

    task automatic check_port(input int p, input logic [1:0] es, input int rq);
        if (es == 2'd3)
            chk(rsp_valid[p] == 1'b0, rq, "idle port valid", 32'(rsp_valid[p]), 0);
        else begin
            chk(rsp_valid[p] == 1'b1, rq, "rsp_valid", 32'(rsp_valid[p]), 1);
            chk(rsp_status[p*2 +: 2] == es, rq, "status", 32'(rsp_status[p*2 +: 2]), 32'(es));
        end
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [VW-1:0] v;
        repeat (3) @(negedge clk);
        // R1: no response while and right after reset
        chk(rsp_valid == '0, 1, "valid in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == '0, 1, "valid after reset", 32'(rsp_valid), 0);

        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            drive(v[66:64], v[63:60], v[59:44], v[43:41], v[40:37], v[36:21]);
            @(negedge clk);
            idle();
            check_port(0, v[20:19], int'(v[70:67]));
            check_port(1, v[18:17], int'(v[70:67]));
            chk(rsp_rdata == v[16:1], int'(v[70:67]), "rdata", 32'(rsp_rdata), 32'(v[16:1]));
            chk(rsp_tag == v[0], int'(v[70:67]), "tag before", 32'(rsp_tag), 32'(v[0]));
        end

        // R9: back-to-back deposit then withdraw on consecutive edges
        drive(3'd1, 4'd10, 16'hBEEF, 3'd0, '0, '0);
        @(negedge clk);
        drive(3'd2, 4'd10, 16'h0, 3'd0, '0, '0);
        chk(rsp_valid == 2'b01 && rsp_status[1:0] == 2'd0 && rsp_tag == 1'b0, 9,
            "first of pair", 32'({rsp_valid, rsp_status[1:0], rsp_tag}), 32'({2'b01, 2'd0, 1'b0}));
        @(negedge clk);
        idle();
        chk(rsp_status[1:0] == 2'd0 && rsp_rdata == 16'hBEEF && rsp_tag == 1'b1, 9,
            "second of pair", 32'({rsp_status[1:0], rsp_rdata, rsp_tag}), 32'({2'd0, 16'hBEEF, 1'b1}));
        @(negedge clk);
        chk(rsp_valid == '0, 9, "no request no answer", 32'(rsp_valid), 0);

        // R1: fill a word, reset, every tag must read empty
        drive(3'd1, 4'd2, 16'h1234, 3'd0, '0, '0);
        @(negedge clk);
        idle();
        chk(rsp_status[1:0] == 2'd0, 2, "fill before reset", 32'(rsp_status[1:0]), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rsp_valid == '0, 1, "valid in second reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        for (int a = 0; a < (1 << AW); a++) begin
            drive(3'd2, AW'(a), '0, 3'd0, '0, '0);
            @(negedge clk);
            idle();
            chk(rsp_status[1:0] == 2'd1 && rsp_tag == 1'b0, 1, "withdraw after reset",
                32'({rsp_status[1:0], rsp_tag}), 32'({2'd1, 1'b0}));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule